// File: doc/BRIEF.md
# Pulse-Width-Coded Motor Command Transmitter

This block turns one motor command (an 11-bit throttle code and a telemetry-request flag) into a 16-bit serial frame. It drives the frame on a single output pin. Every frame bit occupies a fixed period of 40 ticks. The line is high at the start of the period for 14 ticks to send a 0, or for 29 ticks to send a 1, and low for the rest of the period. A 4-bit XOR checksum protects the payload. An internal prescaler derives the tick from the system clock. Two rates are available: a fast variant at 24 MHz ticks and a slow variant at 6 MHz ticks.

Commands enter through a valid/ready handshake. `cmd_ready` is high exactly when no frame is in flight. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. There is no command buffer, so the block applies back-pressure only by holding `cmd_ready` low. A producer that raises `cmd_valid` while `cmd_ready` is low is ignored and must present the command again. Acceptance clears the prescaler and the bit timer. Several instances given their commands on the same edge therefore produce frames whose bit boundaries line up. A polarity select inverts both the active and the idle levels of the pin.

Top module: `dshot_tx`

## Requirements
- R1: The 12-bit payload is the throttle code in bits 11..1 and the telemetry-request flag in bit 0.
- R2: The checksum is the XOR of payload bits 11..8, 7..4 and 3..0. The frame is the payload in bits 15..4 with the checksum in bits 3..0.
- R3: Frame bits leave the pin starting with bit 15 and ending with bit 0.
- R4: Every bit period lasts 40 ticks. A 1 is active for the first 29 ticks and a 0 for the first 14 ticks, and the line is inactive for the rest of the period.
- R5: One tick lasts CLK_HZ/24 MHz clock cycles when `speed_fast`=1, and CLK_HZ/6 MHz cycles when it is 0. The setting is captured at acceptance.
- R6: Acceptance clears the tick and bit counters. Instances accepted on the same edge raise their pins on the same cycles.
- R7: With `invert`=0 the pin is high when active and low when idle. With `invert`=1 both levels are swapped. The value is captured at acceptance for the frame and followed directly while idle.
- R8: `busy` stays high for exactly 640 ticks from the accepting edge. After that the pin rests at its idle level.
- R9: `cmd_ready` equals the inverse of `busy`. A `cmd_valid` while busy changes neither the frame in flight nor its timing.
- R10: After reset, `busy` is 0, `cmd_ready` is 1 and the pin is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (no frame in flight) |
| cmd_throttle | input | 11 | Throttle code |
| cmd_telem | input | 1 | Telemetry-request flag |
| speed_fast | input | 1 | 1 selects 24 MHz ticks, 0 selects 6 MHz ticks |
| invert | input | 1 | Swap active and idle pin levels |
| busy | output | 1 | Frame in transmission |
| pin | output | 1 | Pulse-width-coded serial output |

## Verification
The hardest situation to reach from the ports is a command offered in the middle of a frame, with different data. It must leave every pulse width and the end time of the frame untouched. The bench raises `cmd_valid` with the inverted throttle code partway through several frames. It then decodes the whole pin waveform and checks it against the first command. Alignment between instances is checked by a second instance that always receives a different throttle on the same edge. Every rising edge of one pin must coincide with a rising edge of the other.

// File: rtl/dshot_pkg.sv
package dshot_pkg;
  localparam int BIT_TICKS  = 40;
  localparam int HIGH_ZERO  = 14;
  localparam int HIGH_ONE   = 29;
  localparam int FRAME_BITS = 16;
  localparam int CSUM_W     = 4;
  localparam int TICK_W     = $clog2(BIT_TICKS);
  localparam int BITIDX_W   = $clog2(FRAME_BITS);
  typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/dshot_frame_build.sv
module dshot_frame_build
  import dshot_pkg::*;
#(
  parameter int THR_W = 11
) (
  input  logic [THR_W-1:0] throttle,
  input  logic             telem,
  output frame_t           frame
);
  localparam int PAY_W = THR_W + 1;
  localparam int NIB   = PAY_W / CSUM_W;

  logic [PAY_W-1:0]  payload;
  logic [CSUM_W-1:0] part [NIB];

  assign payload = {throttle, telem};

  generate
    for (genvar g = 0; g < NIB; g++) begin : g_nib
      if (g == 0) begin : g_first
        assign part[g] = payload[CSUM_W-1:0];
      end else begin : g_rest
        assign part[g] = part[g-1] ^ payload[g*CSUM_W +: CSUM_W];
      end
    end
  endgenerate

  assign frame = {payload, part[NIB-1]};

  // R2: all four nibbles of a well-formed frame XOR to zero
  always_comb begin
    assert_csum_zero_R2: assert ((frame[15:12] ^ frame[11:8] ^ frame[7:4] ^ frame[3:0]) == 4'h0);
  end
endmodule

// File: rtl/dshot_tick_gen.sv
module dshot_tick_gen #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign tick  = run && !clear && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: with a divide of at least two, ticks never come on adjacent cycles
  generate
    if (DIV_FAST > 1 && DIV_SLOW > 1) begin : g_chk
      assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dshot_bit_timer.sv
module dshot_bit_timer
  import dshot_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                tick,
  output logic [TICK_W-1:0]   tick_cnt,
  output logic [BITIDX_W-1:0] bit_idx,
  output logic                frame_end
);
  logic bit_end;

  assign bit_end   = tick && (tick_cnt == TICK_W'(BIT_TICKS - 1));
  assign frame_end = bit_end && (bit_idx == BITIDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (tick) begin
      if (bit_end) begin
        tick_cnt <= '0;
        bit_idx  <= bit_idx + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  // R4: the tick counter never passes the last tick of a bit period
  assert_tick_bound_R4: assert property (@(posedge clk) disable iff (rst)
    tick_cnt <= TICK_W'(BIT_TICKS - 1));
endmodule

// File: rtl/dshot_tx.sv
module dshot_tx
  import dshot_pkg::*;
#(
  parameter int CLK_HZ  = 48_000_000,
  parameter int FAST_HZ = 24_000_000,
  parameter int SLOW_HZ = 6_000_000,
  parameter int THR_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [THR_W-1:0] cmd_throttle,
  input  logic             cmd_telem,
  input  logic             speed_fast,
  input  logic             invert,
  output logic             busy,
  output logic             pin
);
  localparam int DIV_FAST = CLK_HZ / FAST_HZ;
  localparam int DIV_SLOW = CLK_HZ / SLOW_HZ;

  frame_t                frame_w;
  frame_t                frame_q;
  logic                  busy_q;
  logic                  fast_q;
  logic                  inv_q;
  logic                  pin_q;
  logic                  accept;
  logic                  tick;
  logic [TICK_W-1:0]     tick_cnt;
  logic [BITIDX_W-1:0]   bit_idx;
  logic                  frame_end;
  logic                  cur_bit;
  logic [TICK_W-1:0]     high_len;
  logic                  active;

  assign accept = cmd_valid && !busy_q;

  dshot_frame_build #(.THR_W(THR_W)) u_build (
    .throttle (cmd_throttle),
    .telem    (cmd_telem),
    .frame    (frame_w)
  );

  dshot_tick_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .run   (busy_q),
    .fast  (fast_q),
    .tick  (tick)
  );

  dshot_bit_timer u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .tick      (tick),
    .tick_cnt  (tick_cnt),
    .bit_idx   (bit_idx),
    .frame_end (frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      frame_q <= '0;
      fast_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      frame_q <= frame_w;
      fast_q  <= speed_fast;
      inv_q   <= invert;
    end else if (frame_end) begin
      busy_q  <= 1'b0;
    end
  end

  assign cur_bit  = frame_q[(FRAME_BITS-1) - int'(bit_idx)];
  assign high_len = cur_bit ? TICK_W'(HIGH_ONE) : TICK_W'(HIGH_ZERO);
  assign active   = busy_q && (tick_cnt < high_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= invert;
    end else begin
      pin_q <= (busy_q ? inv_q : invert) ^ active;
    end
  end

  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign pin       = pin_q;

  // R9: a frame only starts from an offered command
  assert_start_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(cmd_valid));

  // R9: the frame in flight is never overwritten
  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(frame_q));

  // R6: counters start from zero when a frame begins
  assert_clear_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (tick_cnt == '0 && bit_idx == '0));

  // R8: while idle the pin rests at the idle level
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q) && $stable(invert) && !$past(rst)) |-> (pin_q == invert));
endmodule

// File: tb/tb_dshot_tx.sv
module tb_dshot_tx;
  localparam int DF = 2;
  localparam int DS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [10:0] thr = '0;
  logic [10:0] thr_b = '0;
  logic tel = 1'b0;
  logic spd = 1'b1;
  logic inv = 1'b0;
  logic ready, busy, pin, ready_b, busy_b, pin_b;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dshot_tx dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(ready),
    .cmd_throttle(thr), .cmd_telem(tel), .speed_fast(spd), .invert(inv),
    .busy(busy), .pin(pin)
  );

  dshot_tx dut_b (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(ready_b),
    .cmd_throttle(thr_b), .cmd_telem(tel), .speed_fast(spd), .invert(inv),
    .busy(busy_b), .pin(pin_b)
  );

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
      summary_and_end();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [10:0] t, input logic te);
    int p;
    int c;
    p = int'(t) * 2 + int'(te);
    c = ((p / 256) % 16) ^ ((p / 16) % 16) ^ (p % 16);
    return 16'(p * 16 + c);
  endfunction

  task automatic run_frame(input logic [10:0] t, input logic te, input logic f,
                           input logic iv, input bit inject);
    int d, n, run, nruns, last_rise, rises, bad_w, bad_p, bad_al, bad_rdy;
    logic prev;
    logic prev_b;
    logic a;
    logic ab;
    logic [15:0] got;
    logic [15:0] expv;
    d = f ? DF : DS;
    expv = exp_frame(t, te);
    @(negedge clk);
    thr = t; thr_b = ~t; tel = te; spd = f; inv = iv;
    check(ready == 1'b1, "R9 ready before start", int'(ready), 1);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0; run = 0; nruns = 0; last_rise = -1; rises = 0;
    bad_w = 0; bad_p = 0; bad_al = 0; bad_rdy = 0;
    prev = 1'b0; prev_b = 1'b0; got = '0;
    while (busy && n < 20000) begin
      n++;
      a  = pin ^ iv;
      ab = pin_b ^ iv;
      if (ready != 1'b0) bad_rdy++;
      if ((a && !prev) != (ab && !prev_b)) bad_al++;
      if (a && !prev) begin
        if (last_rise >= 0 && (n - last_rise) != 40 * d) bad_p++;
        last_rise = n;
        rises++;
      end
      if (a) run++;
      if (!a && prev) begin
        if (nruns < 16) begin
          if (run == 29 * d) got[15 - nruns] = 1'b1;
          else if (run != 14 * d) bad_w++;
        end
        nruns++;
        run = 0;
      end
      prev = a; prev_b = ab;
      if (inject && n == 100) begin thr = ~t; tel = ~te; cmd_valid = 1'b1; end
      if (inject && n == 101) cmd_valid = 1'b0;
      @(negedge clk);
    end
    check(got == expv && nruns == 16, inject ? "R9 frame kept under mid-frame valid" : "R1 R2 R3 frame content",
          int'(got), int'(expv));
    check(bad_w == 0, "R4 pulse widths", bad_w, 0);
    check(bad_p == 0 && rises == 16, "R4 bit period", bad_p, 0);
    check(n == 640 * d, "R5 R8 busy duration", n, 640 * d);
    check(bad_al == 0, "R6 aligned edges", bad_al, 0);
    check(bad_rdy == 0, "R9 ready low while busy", bad_rdy, 0);
    @(negedge clk);
    check(pin == iv && ready == 1'b1, "R7 R8 idle after frame", int'(pin), int'(iv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && ready == 1'b1, "R10 reset busy/ready", int'(busy), 0);
    check(pin == 1'b0, "R10 reset pin idle", int'(pin), 0);
    inv = 1'b1;
    repeat (2) @(negedge clk);
    check(pin == 1'b1, "R7 idle follows invert", int'(pin), 1);
    for (int i = 0; i < 72; i++) begin
      int tv;
      tv = (i == 71) ? 2047 : i * 29;
      run_frame(11'(tv), 1'(i), 1'b1, 1'(i >> 1), (i % 9) == 4);
    end
    run_frame(11'd0,    1'b0, 1'b0, 1'b0, 1'b0);
    run_frame(11'd2047, 1'b1, 1'b0, 1'b1, 1'b0);
    run_frame(11'd1365, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame(11'd682,  1'b1, 1'b0, 1'b1, 1'b1);
    summary_and_end();
  end
endmodule